// File: doc/BRIEF.md
# Compare-Driven Waveform Timer Channel

This block is a single timer channel dedicated to waveform generation. A counter, `WIDTH` bits wide (16 by default), advances once on every cycle in which the count-enable pulse is high. Four counting modes are available: plain up counting, up counting that restarts at a programmable limit, and up/down counting that reverses either at the all-ones value or at that limit. Three programmable compare values are provided. The first two only produce events. The third is the limit used by the restart and reversal modes.

Two output lines, A and B, are each driven by a small action table. Each line has four event sources: its own compare, the limit compare, an external event and a trigger. Every source has a 2-bit action: nothing, set, clear or toggle. The external event is an edge on a selectable signal. That signal is either line B's pin or one of three extra inputs. When line B's pin is chosen, line B becomes an input and stops generating a waveform. A local trigger or a trigger shared by all channels zeroes the counter and restarts it counting up. An external event can do the same when enabled.

Clock selection, capture and bus decoding are handled outside the block. Single-cycle status pulses report counter overflow and the three compare matches.

Top module: `wave_timer_ch`

## Requirements
- R1: After reset the count, both lines, `tiob_oe`, every status pulse and all three compare values read zero, and the counter direction is up.
- R2: With `wave_mode` 00 the count rises by one only on cycles where `cnt_tick` is high, holds otherwise, and wraps from all-ones to zero. On that wrapping tick `ovf_flag` pulses for one cycle.
- R3: With `wave_mode` 01 a tick taken while the count equals `rc_q` loads zero instead of incrementing, and `cpc_flag` pulses.
- R4: With `wave_mode` 10 the count rises to all-ones and then falls (all-ones, then all-ones minus one, pulsing `ovf_flag` on the turning tick). It falls to zero and then rises again (zero, then one).
- R5: With `wave_mode` 11 the count rises to `rc_q`, then falls (`rc_q`, then `rc_q`-1, pulsing `cpc_flag`), and after reaching zero rises again.
- R6: A compare with `ra_q` or `rb_q` fires only on a tick taken while the count equals that value. It pulses `cpa_flag` or `cpb_flag` and applies the line's own-compare action. It never alters the count or the direction.
- R7: Each line's action byte holds four 2-bit fields: bits 1:0 own compare, 3:2 limit compare, 5:4 external event, 7:6 trigger. A field value of 00 means no change, 01 set, 10 clear and 11 toggle. The changed line is visible one cycle after the event.
- R8: When several events reach a line in the same cycle, only one action applies. The trigger field wins over the external event field, which wins over the limit compare field, which wins over the own-compare field.
- R9: A pulse on `sw_trig` or `sync_trig` loads zero into the counter and sets the direction to up, regardless of `cnt_tick`. It suppresses compare and overflow events in that cycle and applies the trigger field on both lines.
- R10: `evt_src` picks the event signal: 00 `tiob_in`, 01 `xc_in[0]`, 10 `xc_in[1]`, 11 `xc_in[2]`. `evt_edge` picks the edge: 00 none, 01 rising, 10 falling, 11 both. A detected edge applies the event field, and with `evt_restart` high it also restarts the counter as in R9.
- R11: While `evt_src` is 00, `tiob_oe` is low (one cycle after the selection) and line B holds its value whatever events arrive. Otherwise `tiob_oe` is high and line B follows its actions.
- R12: A cycle with `wr_en` high loads `wr_data` into `ra_q` (`wr_sel` 00), `rb_q` (01) or `rc_q` (10), visible the next cycle. `wr_sel` 11 changes none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count-enable pulse |
| sw_trig | input | 1 | Local trigger |
| sync_trig | input | 1 | Trigger shared by all channels |
| xc_in | input | 3 | Extra event signals 0..2 |
| tiob_in | input | 1 | Line B pin value when used as input |
| wave_mode | input | 2 | Counting mode |
| evt_src | input | 2 | External event source select |
| evt_edge | input | 2 | External event edge select |
| evt_restart | input | 1 | External event restarts the counter |
| act_a | input | 8 | Action fields of line A |
| act_b | input | 8 | Action fields of line B |
| wr_en | input | 1 | Compare value write strobe |
| wr_sel | input | 2 | Compare value select |
| wr_data | input | WIDTH | Compare value to write |
| tioa | output | 1 | Line A |
| tiob | output | 1 | Line B |
| tiob_oe | output | 1 | Line B output enable |
| count | output | WIDTH | Counter value |
| ra_q | output | WIDTH | Compare value A |
| rb_q | output | WIDTH | Compare value B |
| rc_q | output | WIDTH | Limit compare value |
| ovf_flag | output | 1 | Overflow pulse |
| cpa_flag | output | 1 | Compare A pulse |
| cpb_flag | output | 1 | Compare B pulse |
| cpc_flag | output | 1 | Limit compare pulse |

## Verification
A stale direction bit is visible at the ports only at the next turning point. It shows up as a count that keeps rising past the limit or all-ones, or that wraps below zero. The bench therefore walks each up/down mode through both turns and through the tick that follows. A wrong action priority or edge-detector state changes a line one cycle after the event, so each line value is sampled in the cycle right after every stimulus. A compare that fires off its tick, or that disturbs the counter, is exposed by reading the count and the status pulses together on that same cycle.

// File: rtl/wg_pkg.sv
package wg_pkg;

  localparam int NUM_CMP   = 3;
  localparam int NUM_LINES = 2;
  localparam int LIMIT_IDX = 2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    WM_UP      = 2'b00,
    WM_UP_LIM  = 2'b01,
    WM_UPDN    = 2'b10,
    WM_UPDN_LIM = 2'b11
  } wmode_e;

  typedef enum logic [1:0] {
    EDG_NONE = 2'b00,
    EDG_RISE = 2'b01,
    EDG_FALL = 2'b10,
    EDG_BOTH = 2'b11
  } edge_e;

  function automatic logic act_apply(input logic cur, input act_e a);
    case (a)
      ACT_SET: act_apply = 1'b1;
      ACT_CLR: act_apply = 1'b0;
      ACT_TGL: act_apply = ~cur;
      default: act_apply = cur;
    endcase
  endfunction

endpackage

// File: rtl/wg_cmp_regs.sv
module wg_cmp_regs #(
  parameter int WIDTH = 16,
  parameter int NCMP  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_sel,
  input  logic [WIDTH-1:0]           wr_data,
  output logic [NCMP-1:0][WIDTH-1:0] cmp_q
);

  for (genvar g = 0; g < NCMP; g++) begin : g_reg
    logic [WIDTH-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst)                                 val_q <= '0;
      else if (wr_en && wr_sel == 2'(g))       val_q <= wr_data;
    end
    assign cmp_q[g] = val_q;
  end

  // R12: the unused select value leaves every compare value alone
  p_sel_unused_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'b11) |=> $stable(cmp_q));

  // R12: a write to slot 0 is visible on the following cycle
  p_write_slot0_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'b00) |=> (cmp_q[0] == $past(wr_data)));

endmodule

// File: rtl/wg_counter.sv
module wg_counter
  import wg_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] limit,
  output logic [WIDTH-1:0] cnt_q,
  output logic             ovf_evt
);

  localparam logic [WIDTH-1:0] MAXV = '1;

  logic             down_q;
  logic [WIDTH-1:0] cnt_d;
  logic             down_d;
  logic [WIDTH-1:0] top_v;
  logic             at_top;
  wmode_e           wm;

  assign wm     = wmode_e'(mode);
  assign top_v  = mode[0] ? limit : MAXV;
  assign at_top = (cnt_q == top_v);

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    if (restart) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end else if (tick) begin
      case (wm)
        WM_UP: begin
          cnt_d  = cnt_q + 1'b1;
          down_d = 1'b0;
        end
        WM_UP_LIM: begin
          cnt_d  = at_top ? '0 : cnt_q + 1'b1;
          down_d = 1'b0;
        end
        default: begin
          if (!down_q) begin
            if (at_top) begin
              if (cnt_q != '0) begin
                cnt_d  = cnt_q - 1'b1;
                down_d = 1'b1;
              end
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_d  = cnt_q + 1'b1;
              down_d = 1'b0;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign ovf_evt = tick && !restart && (cnt_q == MAXV);

  // R9: any restart leaves the counter at zero heading up
  p_restart_zero_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0 && !down_q));

  // R2: without a tick or restart the count does not move
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(cnt_q));

  // R4: reversal at all-ones in plain up/down mode
  p_turn_max_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && mode == 2'b10 && !down_q && cnt_q == MAXV)
      |=> (down_q && cnt_q == MAXV - 1'b1));

  // R5: the single-direction modes never leave the direction flag set
  p_dir_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !mode[1]) |=> !down_q);

endmodule

// File: rtl/wg_evt_detect.sv
module wg_evt_detect
  import wg_pkg::*;
#(
  parameter int NXC = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pin_b,
  input  logic [NXC-1:0] xc,
  input  logic [1:0]     src,
  input  logic [1:0]     edge_sel,
  output logic           hit
);

  logic  sel_v;
  logic  prev_q;
  logic  rise;
  logic  fall;
  edge_e es;

  always_comb begin
    case (src)
      2'b00:   sel_v = pin_b;
      2'b01:   sel_v = xc[0];
      2'b10:   sel_v = xc[1];
      default: sel_v = xc[NXC-1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sel_v;
  end

  assign es   = edge_e'(edge_sel);
  assign rise = sel_v && !prev_q;
  assign fall = !sel_v && prev_q;

  always_comb begin
    case (es)
      EDG_RISE: hit = rise;
      EDG_FALL: hit = fall;
      EDG_BOTH: hit = rise || fall;
      default:  hit = 1'b0;
    endcase
  end

  // R10: a held-steady source never reports an edge
  p_steady_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    ($stable(src) && $stable(sel_v) && $stable(prev_q)
      && (sel_v == prev_q)) |-> !hit);

endmodule

// File: rtl/wg_line.sv
module wg_line
  import wg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       drive_en,
  input  logic       trig_hit,
  input  logic       ev_hit,
  input  logic       lim_hit,
  input  logic       own_hit,
  input  logic [7:0] act,
  output logic       line_q
);

  act_e chosen;

  always_comb begin
    if (trig_hit)      chosen = act_e'(act[7:6]);
    else if (ev_hit)   chosen = act_e'(act[5:4]);
    else if (lim_hit)  chosen = act_e'(act[3:2]);
    else if (own_hit)  chosen = act_e'(act[1:0]);
    else               chosen = ACT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst)           line_q <= 1'b0;
    else if (drive_en) line_q <= act_apply(line_q, chosen);
  end

  // R11: an undriven line keeps its value
  p_undriven_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !drive_en |=> $stable(line_q));

  // R8: a trigger set request wins whatever else arrives
  p_trig_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (drive_en && trig_hit && act[7:6] == 2'b01) |=> line_q);

  // R7: no event means no change
  p_quiet_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!trig_hit && !ev_hit && !lim_hit && !own_hit) |=> $stable(line_q));

endmodule

// File: rtl/wave_timer_ch.sv
module wave_timer_ch
  import wg_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int NXC   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_tick,
  input  logic             sw_trig,
  input  logic             sync_trig,
  input  logic [NXC-1:0]   xc_in,
  input  logic             tiob_in,
  input  logic [1:0]       wave_mode,
  input  logic [1:0]       evt_src,
  input  logic [1:0]       evt_edge,
  input  logic             evt_restart,
  input  logic [7:0]       act_a,
  input  logic [7:0]       act_b,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic             tioa,
  output logic             tiob,
  output logic             tiob_oe,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] ra_q,
  output logic [WIDTH-1:0] rb_q,
  output logic [WIDTH-1:0] rc_q,
  output logic             ovf_flag,
  output logic             cpa_flag,
  output logic             cpb_flag,
  output logic             cpc_flag
);

  logic [NUM_CMP-1:0][WIDTH-1:0] cmp_v;
  logic [NUM_CMP-1:0]            cmp_hit;
  logic [NUM_LINES-1:0]          line_v;
  logic [NUM_LINES-1:0]          line_drive;
  logic [NUM_LINES-1:0][7:0]     line_act;
  logic                          trig_any;
  logic                          ev_hit;
  logic                          restart;
  logic                          ovf_evt;
  logic                          b_is_output;

  wg_cmp_regs #(.WIDTH(WIDTH), .NCMP(NUM_CMP)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cmp_q(cmp_v)
  );

  wg_evt_detect #(.NXC(NXC)) u_evt (
    .clk(clk), .rst(rst), .pin_b(tiob_in), .xc(xc_in),
    .src(evt_src), .edge_sel(evt_edge), .hit(ev_hit)
  );

  assign trig_any    = sw_trig || sync_trig;
  assign restart     = trig_any || (ev_hit && evt_restart);
  assign b_is_output = (evt_src != 2'b00);

  wg_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst(rst), .tick(cnt_tick), .restart(restart),
    .mode(wave_mode), .limit(cmp_v[LIMIT_IDX]),
    .cnt_q(count), .ovf_evt(ovf_evt)
  );

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    assign cmp_hit[c] = cnt_tick && !restart && (count == cmp_v[c]);
  end

  assign line_act[0]   = act_a;
  assign line_act[1]   = act_b;
  assign line_drive[0] = 1'b1;
  assign line_drive[1] = b_is_output;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    wg_line u_line (
      .clk(clk), .rst(rst), .drive_en(line_drive[l]),
      .trig_hit(trig_any), .ev_hit(ev_hit),
      .lim_hit(cmp_hit[LIMIT_IDX]), .own_hit(cmp_hit[l]),
      .act(line_act[l]), .line_q(line_v[l])
    );
  end

  assign tioa = line_v[0];
  assign tiob = line_v[1];
  assign ra_q = cmp_v[0];
  assign rb_q = cmp_v[1];
  assign rc_q = cmp_v[LIMIT_IDX];

  always_ff @(posedge clk) begin
    if (rst) begin
      tiob_oe  <= 1'b0;
      ovf_flag <= 1'b0;
      cpa_flag <= 1'b0;
      cpb_flag <= 1'b0;
      cpc_flag <= 1'b0;
    end else begin
      tiob_oe  <= b_is_output;
      ovf_flag <= ovf_evt;
      cpa_flag <= cmp_hit[0];
      cpb_flag <= cmp_hit[1];
      cpc_flag <= cmp_hit[LIMIT_IDX];
    end
  end

  // R6: a compare pulse always traces back to a tick
  p_cmp_needs_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (cpa_flag || cpb_flag || cpc_flag) |-> $past(cnt_tick));

  // R6: a compare A match does not steer the counter in plain up mode
  p_cmp_a_no_reset_r6: assert property (@(posedge clk) disable iff (rst)
    (cmp_hit[0] && wave_mode == 2'b00) |=> (count == $past(count) + 1'b1));

  // R9: a trigger blocks compare and overflow pulses in its cycle
  p_trig_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    trig_any |=> !(cpa_flag || cpb_flag || cpc_flag || ovf_flag));

  // R3: limit restart mode returns to zero after a limit match
  p_lim_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (cmp_hit[LIMIT_IDX] && wave_mode == 2'b01) |=> (count == '0));

endmodule

// File: tb/wave_timer_ch_test.sv
module wave_timer_ch_test;

  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_tick = 0, sw_trig = 0, sync_trig = 0, tiob_in = 0, evt_restart = 0;
  logic [2:0] xc_in = '0;
  logic [1:0] wave_mode = '0, evt_src = '0, evt_edge = '0, wr_sel = '0;
  logic [7:0] act_a = '0, act_b = '0;
  logic wr_en = 0;
  logic [W-1:0] wr_data = '0;
  logic tioa, tiob, tiob_oe, ovf_flag, cpa_flag, cpb_flag, cpc_flag;
  logic [W-1:0] count, ra_q, rb_q, rc_q;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  // 100 MHz: 10 time-unit period
  always #5 clk = ~clk;

  wave_timer_ch #(.WIDTH(W), .NXC(3)) uut (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .sw_trig(sw_trig),
    .sync_trig(sync_trig), .xc_in(xc_in), .tiob_in(tiob_in),
    .wave_mode(wave_mode), .evt_src(evt_src), .evt_edge(evt_edge),
    .evt_restart(evt_restart), .act_a(act_a), .act_b(act_b),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tioa(tioa), .tiob(tiob), .tiob_oe(tiob_oe), .count(count),
    .ra_q(ra_q), .rb_q(rb_q), .rc_q(rc_q), .ovf_flag(ovf_flag),
    .cpa_flag(cpa_flag), .cpb_flag(cpb_flag), .cpc_flag(cpc_flag)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic trig();
    sw_trig = 1'b1; cyc(1); sw_trig = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; cyc(1); wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "count", count, 0);
    chk("R1", "tioa", tioa, 0);
    chk("R1", "tiob", tiob, 0);
    chk("R1", "tiob_oe", tiob_oe, 0);
    chk("R1", "flags", {ovf_flag, cpa_flag, cpb_flag, cpc_flag}, 0);
    chk("R1", "cmp values", {ra_q, rb_q, rc_q}, 0);
  endtask

  task automatic t_regs();
    wr(2'b00, 8'd5); chk("R12", "ra", ra_q, 5);
    wr(2'b01, 8'd9); chk("R12", "rb", rb_q, 9);
    wr(2'b10, 8'd20); chk("R12", "rc", rc_q, 20);
    wr(2'b11, 8'd77);
    chk("R12", "sel 11 ignored", {ra_q, rb_q, rc_q}, {8'd5, 8'd9, 8'd20});
  endtask

  task automatic t_mode_up();
    wave_mode = 2'b00; trig();
    ticks(3); chk("R2", "count after 3", count, 3);
    cyc(2); chk("R2", "hold without tick", count, 3);
    ticks(2); chk("R6", "no early cmp A", cpa_flag, 0);
    ticks(1);
    chk("R6", "cmp A pulse", cpa_flag, 1);
    chk("R6", "cmp A leaves count", count, 6);
    ticks(1); chk("R6", "cmp A one cycle", cpa_flag, 0);
    ticks(MAXV - 7); chk("R2", "at max", count, MAXV);
    ticks(1);
    chk("R2", "wrap", count, 0);
    chk("R2", "ovf pulse", ovf_flag, 1);
    cyc(1); chk("R2", "ovf one cycle", ovf_flag, 0);
  endtask

  task automatic t_mode_uplim();
    wave_mode = 2'b01; trig();
    ticks(20); chk("R3", "at limit", count, 20);
    ticks(1);
    chk("R3", "restart at limit", count, 0);
    chk("R3", "limit pulse", cpc_flag, 1);
  endtask

  task automatic t_mode_updn();
    wave_mode = 2'b10; trig();
    ticks(MAXV); chk("R4", "at max", count, MAXV);
    ticks(1);
    chk("R4", "turn down", count, MAXV - 1);
    chk("R4", "ovf at turn", ovf_flag, 1);
    ticks(MAXV - 2); chk("R4", "falling", count, 1);
    ticks(1); chk("R4", "bottom", count, 0);
    ticks(1); chk("R4", "turn up", count, 1);
  endtask

  task automatic t_mode_updnlim();
    wave_mode = 2'b11; trig();
    ticks(20); chk("R5", "at limit", count, 20);
    ticks(1);
    chk("R5", "turn down", count, 19);
    chk("R5", "limit pulse", cpc_flag, 1);
    ticks(19); chk("R5", "bottom", count, 0);
    ticks(1); chk("R5", "turn up", count, 1);
  endtask

  task automatic t_actions();
    wave_mode = 2'b00;
    act_a = 8'h40; trig(); chk("R7", "set", tioa, 1);
    chk("R9", "trigger zeroes", count, 0);
    act_a = 8'hC0; trig(); chk("R7", "toggle to 0", tioa, 0);
    trig(); chk("R7", "toggle to 1", tioa, 1);
    act_a = 8'h80; trig(); chk("R7", "clear", tioa, 0);
    act_a = 8'h00; trig(); chk("R7", "none", tioa, 0);
    // own compare toggles line A at count 5, compare B sets line B at 9
    act_a = 8'h03; act_b = 8'h01; trig();
    ticks(5); chk("R6", "A before match", tioa, 0);
    ticks(1); chk("R6", "A toggled by cmp", tioa, 1);
    chk("R6", "B not yet", tiob, 0);
    ticks(4); chk("R6", "B set by cmp", tiob, 1);
    chk("R6", "cmp B pulse", cpb_flag, 1);
    act_b = 8'h00;
  endtask

  task automatic t_sync();
    act_a = 8'h80; trig(); ticks(4);
    act_a = 8'h40; sync_trig = 1'b1; cyc(1); sync_trig = 1'b0;
    chk("R9", "shared trigger zeroes", count, 0);
    chk("R9", "shared trigger action", tioa, 1);
  endtask

  task automatic t_priority();
    wave_mode = 2'b01; wr(2'b00, 8'd20);
    act_a = 8'h49; trig();
    ticks(20); chk("R8", "before tie", tioa, 1);
    ticks(1); chk("R8", "limit beats own", tioa, 0);
    evt_src = 2'b01; evt_edge = 2'b01; evt_restart = 1'b0;
    act_a = 8'h18;
    ticks(20);
    cnt_tick = 1'b1; xc_in[0] = 1'b1; cyc(1); cnt_tick = 1'b0;
    chk("R8", "event beats limit", tioa, 1);
    xc_in[0] = 1'b0; cyc(1);
    act_a = 8'h90;
    sw_trig = 1'b1; xc_in[0] = 1'b1; cyc(1); sw_trig = 1'b0;
    chk("R8", "trigger beats event", tioa, 0);
    xc_in[0] = 1'b0; cyc(1);
    wr(2'b00, 8'd5);
  endtask

  task automatic t_event();
    logic v;
    wave_mode = 2'b00; evt_src = 2'b01; act_a = 8'h30;
    evt_edge = 2'b01; v = tioa;
    xc_in[0] = 1'b1; cyc(1); chk("R10", "rise toggles", tioa, !v);
    cyc(1); chk("R10", "steady high", tioa, !v);
    xc_in[0] = 1'b0; cyc(1); chk("R10", "fall ignored", tioa, !v);
    evt_edge = 2'b10;
    xc_in[0] = 1'b1; cyc(1); chk("R10", "rise ignored", tioa, !v);
    xc_in[0] = 1'b0; cyc(1); chk("R10", "fall toggles", tioa, v);
    evt_edge = 2'b11;
    xc_in[0] = 1'b1; cyc(1); chk("R10", "both rise", tioa, !v);
    xc_in[0] = 1'b0; cyc(1); chk("R10", "both fall", tioa, v);
    evt_edge = 2'b00;
    xc_in[0] = 1'b1; cyc(1); chk("R10", "edge none", tioa, v);
    xc_in[0] = 1'b0; cyc(1);
    evt_src = 2'b11; evt_edge = 2'b01;
    xc_in[0] = 1'b1; cyc(1); chk("R10", "unselected input", tioa, v);
    xc_in[0] = 1'b0;
    xc_in[2] = 1'b1; cyc(1); chk("R10", "xc2 selected", tioa, !v);
    xc_in[2] = 1'b0; cyc(1);
    act_a = 8'h00; trig(); ticks(7); chk("R10", "count before", count, 7);
    evt_restart = 1'b1; xc_in[2] = 1'b1; cyc(1);
    chk("R10", "event restart", count, 0);
    xc_in[2] = 1'b0; evt_restart = 1'b0; cyc(1);
  endtask

  task automatic t_pin_input();
    logic vb, va;
    evt_src = 2'b00; evt_edge = 2'b01; cyc(1);
    chk("R11", "oe low", tiob_oe, 0);
    act_b = 8'hC0; vb = tiob;
    trig(); chk("R11", "B holds", tiob, vb);
    act_a = 8'h30; va = tioa;
    tiob_in = 1'b1; cyc(1); chk("R11", "pin edge reaches A", tioa, !va);
    chk("R11", "B still holds", tiob, vb);
    tiob_in = 1'b0; cyc(1);
    evt_src = 2'b01; cyc(1);
    chk("R11", "oe high", tiob_oe, 1);
    trig(); chk("R11", "B driven again", tiob, !vb);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    evt_src = 2'b01;
    t_regs();
    t_mode_up();
    t_mode_uplim();
    t_mode_updn();
    t_mode_updnlim();
    t_actions();
    t_sync();
    t_priority();
    t_event();
    t_pin_input();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule